// File: doc/BRIEF.md
# Packet-Driven Stage Clock-Enable Scheduler

This block decides, once per transport packet, which processing stages of a stream demultiplexer receive a clock. Four stages are covered: the sync-byte checker, the packet-identifier filter, the clock-reference extraction stage and the table section filter. When a packet begins, the upstream parser presents that packet's content class, a validity flag and a flag saying whether the stored table needs refreshing. The scheduler turns these into a per-stage enable mask. The enables are registered and are meant to drive clock-gate cells. Each stage also has a saturating counter of the cycles it spent gated off, so that gating ratios can be measured.

A two-state machine governs the outputs. `ST_WAKE` holds every enable high and is entered at reset and whenever stream lock is lost. The transition `ST_WAKE -> ST_TRACK` fires on a packet start that arrives while lock is held. In `ST_TRACK` the enables follow the mask of the current packet. The transition `ST_TRACK -> ST_WAKE` fires as soon as lock drops. The sync checker is only needed on the first byte of each packet, so in `ST_TRACK` its enable is a single-cycle pulse. The pulse lands on the cycle that carries the next packet's first byte.

Top module: `tsgate_sched`

## Requirements
- R1: A packet of class 2'b00 (video) sets the identifier filter enable high and the extraction and table filter enables low.
- R2: A valid packet of class 2'b10 (table) with the update flag low sets the identifier filter enable high. The sync, extraction and table filter enables are low for that packet.
- R3: A packet of class 2'b10 with the validity flag low drives all four enables low for that packet, including the sync pulse.
- R4: A valid packet of class 2'b10 with the update flag high sets the identifier, extraction and table filter enables high and permits the sync pulse.
- R5: Class 2'b01 (audio) sets the identifier and extraction enables high and the table filter enable low. Class 2'b11 (null) sets only the identifier enable high. Both classes permit the sync pulse.
- R6: In ST_TRACK the sync enable is high for exactly one cycle: the cycle after a cycle in which the byte counter equals PKT_LEN-1 (187 by default). It pulses only if the current packet's class permits it.
- R7: Mask enables change one cycle after a packet start sampled with lock high. While lock stays high they hold constant for the rest of the packet.
- R8: After reset, and in ST_WAKE, all four enables (sync included) are continuously high. A packet start without lock leaves the block in ST_WAKE.
- R9: Lock going low forces all enables high on the next cycle. They stay high until a packet start is seen with lock high again.
- R10: Each stage's idle counter resets to 0 and adds one on every clock edge at which that stage's enable is low. It holds at 2^IDLE_W-1 once it reaches it.
- R11: For classes 2'b00, 2'b01 and 2'b11 the validity and update flags have no effect on the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_sync | input | 1 | Stream lock held |
| pkt_start | input | 1 | First byte of a packet is present this cycle |
| pkt_cls | input | 2 | Content class: 00 video, 01 audio, 10 table, 11 null |
| pkt_valid | input | 1 | Packet passed validation |
| tbl_update | input | 1 | Stored table needs refreshing from this packet |
| byte_cnt | input | $clog2(PKT_LEN) | Byte index within the packet |
| en_sync | output | 1 | Sync checker clock enable |
| en_pid | output | 1 | Identifier filter clock enable |
| en_pcr | output | 1 | Clock-reference extraction clock enable |
| en_tbl | output | 1 | Table section filter clock enable |
| idle_sync | output | IDLE_W | Gated-off cycles of the sync checker |
| idle_pid | output | IDLE_W | Gated-off cycles of the identifier filter |
| idle_pcr | output | IDLE_W | Gated-off cycles of the extraction stage |
| idle_tbl | output | IDLE_W | Gated-off cycles of the table filter |

## Verification
Every enable is one register away from the inputs, so a packet start or a loss of lock sampled at an edge shows up at the next edge. The sync pulse follows one edge after the last-byte count. The bench drives inputs just after the falling edge and compares every enable at the following falling edge, against a per-cycle model built from the class rules. An idle counter adds one at the edge where its stage's enable was already low, which puts it one cycle behind that enable. The bench therefore updates its expected counts from the enables it predicted for the previous cycle, and compares them at the end of every packet.

// File: rtl/tsgate_pkg.sv
package tsgate_pkg;

    typedef enum logic [1:0] {
        CLS_VIDEO = 2'b00,
        CLS_AUDIO = 2'b01,
        CLS_TABLE = 2'b10,
        CLS_NULL  = 2'b11
    } pkt_cls_e;

    typedef enum logic {
        ST_WAKE  = 1'b0,
        ST_TRACK = 1'b1
    } sched_st_e;

    localparam int N_STG    = 4;
    localparam int STG_TBL  = 0;
    localparam int STG_PCR  = 1;
    localparam int STG_PID  = 2;
    localparam int STG_SYNC = 3;

endpackage

// File: rtl/tsgate_policy.sv
module tsgate_policy
    import tsgate_pkg::*;
(
    input  logic [1:0]       cls,
    input  logic             valid,
    input  logic             upd,
    output logic [N_STG-1:0] mask
);

    always_comb begin
        mask = '0;
        unique case (pkt_cls_e'(cls))
            CLS_VIDEO: begin
                mask[STG_SYNC] = 1'b1;
                mask[STG_PID]  = 1'b1;
            end
            CLS_AUDIO: begin
                mask[STG_SYNC] = 1'b1;
                mask[STG_PID]  = 1'b1;
                mask[STG_PCR]  = 1'b1;
            end
            CLS_NULL: begin
                mask[STG_SYNC] = 1'b1;
                mask[STG_PID]  = 1'b1;
            end
            CLS_TABLE: begin
                if (!valid)
                    mask = '0;
                else if (upd)
                    mask = '1;
                else
                    mask[STG_PID] = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/tsgate_idle_ctr.sv
module tsgate_idle_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gate_on,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (!gate_on && count != TOP)
            count <= count + 1'b1;
    end

endmodule

// File: rtl/tsgate_sched.sv
module tsgate_sched
    import tsgate_pkg::*;
#(
    parameter  int PKT_LEN = 188,
    parameter  int IDLE_W  = 16,
    localparam int BC_W    = $clog2(PKT_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sync,
    input  logic              pkt_start,
    input  logic [1:0]        pkt_cls,
    input  logic              pkt_valid,
    input  logic              tbl_update,
    input  logic [BC_W-1:0]   byte_cnt,
    output logic              en_sync,
    output logic              en_pid,
    output logic              en_pcr,
    output logic              en_tbl,
    output logic [IDLE_W-1:0] idle_sync,
    output logic [IDLE_W-1:0] idle_pid,
    output logic [IDLE_W-1:0] idle_pcr,
    output logic [IDLE_W-1:0] idle_tbl
);

    localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(PKT_LEN - 1);

    sched_st_e        st_q, st_d;
    logic [N_STG-1:0] pol_mask, mask_q, mask_d;
    logic [N_STG-1:0] en_d, en_q;
    logic             load;
    logic [IDLE_W-1:0] idle_arr [N_STG];

    assign load = in_sync && pkt_start;

    tsgate_policy u_policy (
        .cls   (pkt_cls),
        .valid (pkt_valid),
        .upd   (tbl_update),
        .mask  (pol_mask)
    );

    assign mask_d = load ? pol_mask : mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '1;
        else
            mask_q <= mask_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAKE:  if (load)     st_d = ST_TRACK;
            ST_TRACK: if (!in_sync) st_d = ST_WAKE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_WAKE;
        else
            st_q <= st_d;
    end

    // output decode, registered so that enables only move on clean edges
    always_comb begin
        en_d = '1;
        unique case (st_d)
            ST_WAKE:  en_d = '1;
            ST_TRACK: begin
                en_d           = mask_d;
                en_d[STG_SYNC] = mask_d[STG_SYNC] && (byte_cnt == LAST_BYTE);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= '1;
        else
            en_q <= en_d;
    end

    assign en_sync = en_q[STG_SYNC];
    assign en_pid  = en_q[STG_PID];
    assign en_pcr  = en_q[STG_PCR];
    assign en_tbl  = en_q[STG_TBL];

    for (genvar g = 0; g < N_STG; g++) begin : g_idle
        tsgate_idle_ctr #(.W(IDLE_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .gate_on (en_q[g]),
            .count   (idle_arr[g])
        );
    end

    assign idle_sync = idle_arr[STG_SYNC];
    assign idle_pid  = idle_arr[STG_PID];
    assign idle_pcr  = idle_arr[STG_PCR];
    assign idle_tbl  = idle_arr[STG_TBL];

endmodule

// File: rtl/tsgate_sched_chk.sv
module tsgate_sched_chk #(
    parameter  int PKT_LEN = 188,
    parameter  int IDLE_W  = 16,
    localparam int BC_W    = $clog2(PKT_LEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_sync,
    input logic              pkt_start,
    input logic [1:0]        pkt_cls,
    input logic              pkt_valid,
    input logic              tbl_update,
    input logic [BC_W-1:0]   byte_cnt,
    input logic              en_sync,
    input logic              en_pid,
    input logic              en_pcr,
    input logic              en_tbl,
    input logic [IDLE_W-1:0] idle_pid,
    input logic              st_q
);

    localparam logic [BC_W-1:0]   LAST_BYTE = BC_W'(PKT_LEN - 1);
    localparam logic [IDLE_W-1:0] CNT_TOP   = '1;

    a_r1_video_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && pkt_start && pkt_cls == 2'b00) |=> (en_pid && !en_pcr && !en_tbl));

    a_r2_table_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && pkt_start && pkt_cls == 2'b10 && pkt_valid && !tbl_update)
        |=> (en_pid && !en_sync && !en_pcr && !en_tbl));

    a_r3_table_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && pkt_start && pkt_cls == 2'b10 && !pkt_valid)
        |=> (!en_pid && !en_sync && !en_pcr && !en_tbl));

    a_r4_table_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && pkt_start && pkt_cls == 2'b10 && pkt_valid && tbl_update)
        |=> (en_pid && en_pcr && en_tbl));

    a_r6_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q && in_sync && byte_cnt != LAST_BYTE) |=> !en_sync);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && !pkt_start) |=> ($stable(en_pid) && $stable(en_pcr) && $stable(en_tbl)));

    a_r9_lock_lost: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sync |=> (en_sync && en_pid && en_pcr && en_tbl));

    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_pid == CNT_TOP) |=> (idle_pid == CNT_TOP));

    a_r10_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        en_pid |=> $stable(idle_pid));

endmodule

bind tsgate_sched tsgate_sched_chk #(.PKT_LEN(PKT_LEN), .IDLE_W(IDLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_sync    (in_sync),
    .pkt_start  (pkt_start),
    .pkt_cls    (pkt_cls),
    .pkt_valid  (pkt_valid),
    .tbl_update (tbl_update),
    .byte_cnt   (byte_cnt),
    .en_sync    (en_sync),
    .en_pid     (en_pid),
    .en_pcr     (en_pcr),
    .en_tbl     (en_tbl),
    .idle_pid   (idle_pid),
    .st_q       (st_q)
);

// File: tb/sim_tsgate_sched.sv
module sim_tsgate_sched;

    localparam int PKT_LEN = 188;
    localparam int IDLE_W  = 10;
    localparam int BC_W    = $clog2(PKT_LEN);
    localparam int CMAX    = (1 << IDLE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_sync = 1'b0;
    logic              pkt_start = 1'b0;
    logic [1:0]        pkt_cls = 2'b00;
    logic              pkt_valid = 1'b0;
    logic              tbl_update = 1'b0;
    logic [BC_W-1:0]   byte_cnt = '0;
    logic              en_sync, en_pid, en_pcr, en_tbl;
    logic [IDLE_W-1:0] idle_sync, idle_pid, idle_pcr, idle_tbl;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "";
    bit    sync_base = 1'b0;

    // bench model: index 3 sync, 2 pid, 1 pcr, 0 tbl
    bit       m_trk = 1'b0;
    bit [3:0] m_mask = 4'hF;
    bit [3:0] m_en = 4'hF;
    int       m_cnt [4] = '{0, 0, 0, 0};

    always #10 clk = ~clk;

    tsgate_sched #(.PKT_LEN(PKT_LEN), .IDLE_W(IDLE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_sync(in_sync), .pkt_start(pkt_start),
        .pkt_cls(pkt_cls), .pkt_valid(pkt_valid), .tbl_update(tbl_update),
        .byte_cnt(byte_cnt), .en_sync(en_sync), .en_pid(en_pid), .en_pcr(en_pcr),
        .en_tbl(en_tbl), .idle_sync(idle_sync), .idle_pid(idle_pid),
        .idle_pcr(idle_pcr), .idle_tbl(idle_tbl)
    );

    function automatic bit [3:0] want(int cls, bit v, bit u);
        case (cls)
            0: return 4'b1100;                           // R1
            1: return 4'b1110;                           // R5 audio
            3: return 4'b1100;                           // R5 null
            default: return !v ? 4'b0000 : (u ? 4'b1111 : 4'b0100);  // R3 / R4 / R2
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        for (int i = 0; i < 4; i++)
            if (!m_en[i] && m_cnt[i] < CMAX) m_cnt[i]++;
        if (!in_sync) m_trk = 1'b0;
        else if (pkt_start) begin
            m_trk  = 1'b1;
            m_mask = want(int'(pkt_cls), pkt_valid, tbl_update);
        end
        m_en = m_trk ? {m_mask[3] && (int'(byte_cnt) == PKT_LEN - 1), m_mask[2:0]} : 4'hF;
        @(posedge clk);
        @(negedge clk);
        check(en_sync == m_en[3], m_trk ? "R6 sync pulse" : "R8 sync held high",
              int'(en_sync), int'(m_en[3]));
        check({en_pid, en_pcr, en_tbl} == m_en[2:0], tag,
              int'({en_pid, en_pcr, en_tbl}), int'(m_en[2:0]));
    endtask

    task automatic check_counts();
        check(int'(idle_sync) == m_cnt[3], "R10 sync idle", int'(idle_sync), m_cnt[3]);
        check(int'(idle_pid)  == m_cnt[2], "R10 pid idle",  int'(idle_pid),  m_cnt[2]);
        check(int'(idle_pcr)  == m_cnt[1], "R10 pcr idle",  int'(idle_pcr),  m_cnt[1]);
        check(int'(idle_tbl)  == m_cnt[0], "R10 tbl idle",  int'(idle_tbl),  m_cnt[0]);
    endtask

    task automatic send(int cls, bit v, bit u, int drop_lo, int drop_hi, string t);
        tag = t;
        for (int b = 0; b < PKT_LEN; b++) begin
            byte_cnt   = BC_W'(b);
            pkt_start  = (b == 0);
            pkt_cls    = 2'(cls);
            pkt_valid  = v;
            tbl_update = u;
            in_sync    = sync_base && !(b >= drop_lo && b < drop_hi);
            tick();
        end
        check_counts();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state, R10: counters cleared
        check({en_sync, en_pid, en_pcr, en_tbl} == 4'hF, "R8 reset enables",
              int'({en_sync, en_pid, en_pcr, en_tbl}), 15);
        check_counts();

        // R8: packet start without lock is ignored
        sync_base = 1'b0;
        send(2, 1'b0, 1'b0, 0, 0, "R8 no lock");

        // R1..R5, R7, R11: sweep class x valid x update
        sync_base = 1'b1;
        for (int c = 0; c < 4; c++)
            for (int v = 0; v < 2; v++)
                for (int u = 0; u < 2; u++)
                    send(c, v[0], u[0], 0, 0,
                         c == 0 ? "R1 R7 R11 video" :
                         c == 2 ? (v == 0 ? "R3 R7 bad table" :
                                   (u == 1 ? "R4 R7 table refresh" : "R2 R7 table keep")) :
                         "R5 R7 R11 audio/null");

        // R9: lock lost mid-packet, regained without a start
        send(0, 1'b1, 1'b0, 60, 65, "R9 lock loss");
        send(2, 1'b1, 1'b0, 0, 0, "R9 relock");

        // R10: saturation through all-off packets
        for (int k = 0; k < 7; k++)
            send(2, 1'b0, 1'b0, 0, 0, "R3 R10 saturate");
        check(int'(idle_pid) == CMAX, "R10 saturated value", int'(idle_pid), CMAX);

        summary();
        $finish;
    end

endmodule